// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the software-visible face of a simple bus-master DMA channel. It holds four 32-bit words: a control/status word, a transfer address, a byte count and a base (upper) address. A host reaches them through a single-cycle word port. The data movement, address translation and the attached disk or network controller all live elsewhere. This block only stores their settings and drives three sideband lines toward them: a level DMA-enable, a one-cycle device reset pulse and a gated interrupt.

The control word mixes writable bits with bits that hardware owns. The version field is hard-wired. The interrupt-pending flag follows the peripheral's request line, and the address-loaded flag is set by hardware. A control write has side effects. Setting the reset bit fires a pulse to the device. Setting the drain bit on its own is stripped before the value is stored. Writing all zeros is turned into a drain request. Any write to the address word marks the channel as loaded.

The parameter `WIDE_WINDOW` selects the network flavour of the block, whose window is 32 bytes wide. In that flavour, the upper 16 bytes alias the lower 16, and accesses beyond the window are dropped. In the default flavour, every address aliases onto the four words.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, the control word reads 0xA0000000; the address, count and base words read 0; and irqOut, devResetPulse and dmaEnable are 0.
- R2: The word is selected by address bits [3:2]: 0 is control, 1 is address, 2 is count and 3 is base. Offsets 0x10 to 0x1F reach the same four words as 0x00 to 0x0F.
- R3: In the control word, the bits of mask 0xFE000007 ignore written data and keep their stored value. Bits 31 and 29 (0xA0000000) always read 1, and bits 2:1 always read 0.
- R4: A control write with bit 7 set drives devResetPulse high for exactly the next cycle, and the written value is stored unchanged apart from the read-only bits. In every other cycle, devResetPulse is 0.
- R5: A control write with bit 7 clear and bit 6 set stores the value with bit 6 cleared.
- R6: A control write of 0x00000000 stores 0x00000040 in the writable bits.
- R7: dmaEnable equals control bit 9 and changes only in the cycle after a control write.
- R8: Control bit 0 (interrupt pending) reads as the level of periphIrq sampled at the previous clock edge.
- R9: irqOut is high exactly when control bit 0 and control bit 4 (interrupt enable) are both 1.
- R10: A write to the address word (offset 0x4) stores the data and sets control bit 26. Only reset clears bit 26.
- R11: The count (0x8) and base (0xC) words are plain storage: they read back the last value written and have no side effect on the other words.
- R12: With WIDE_WINDOW=1, writes at offsets above 0x1F change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, same cycle |
| periphIrq | input | 1 | Interrupt level from the attached device |
| irqOut | output | 1 | Gated interrupt to the host |
| devResetPulse | output | 1 | One-cycle reset to the attached device |
| dmaEnable | output | 1 | Level enable to the attached device |

## Verification
Some rules are checked on every cycle. The version and zero bits must read correctly on any control read, and out-of-window reads must return zero. The reset pulse must follow a reset-bit write and nothing else. dmaEnable must move only after a control write, and to the written bit 9. The interrupt output must never be high without an earlier request, and the loaded flag must be visible after an address write. Other rules depend on the data history, and only the bench's reference model, compared on every clock, can show them. These include the drain-bit rewrite, the zero-write conversion, the merge of read-only bits with stored values, aliasing across the 32-byte window, and the independence of the count and base words.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 2;
  localparam int REG_CNT  = 1 << IDX_W;

  localparam logic [WORD_W-1:0] VERSION_VAL = 32'hA000_0000;
  localparam logic [WORD_W-1:0] RO_MASK     = 32'hFE00_0007;

  localparam int B_PEND   = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_DRST   = 7;
  localparam int B_EN     = 9;
  localparam int B_LOADED = 26;

  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR = 2'd1;

  typedef struct packed {
    logic             inWindow;
    logic [IDX_W-1:0] idx;
    logic             wrCtrl;
    logic             wrAddr;
    logic             wrPlain;
  } regStrobe_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDE_WINDOW = 0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int WINDOW_LAST = 31;

  logic inWin;
  logic wrHit;

  // Default flavour: the whole address space aliases onto four words.
  assign inWin = (WIDE_WINDOW == 0) || (busAddr <= ADDR_W'(WINDOW_LAST));
  assign wrHit = busValid && busWrite && inWin;

  always_comb begin
    strobe          = '0;
    strobe.inWindow = inWin;
    strobe.idx      = busAddr[IDX_W+1:2];
    strobe.wrCtrl   = wrHit && (busAddr[IDX_W+1:2] == IDX_CTRL);
    strobe.wrAddr   = wrHit && (busAddr[IDX_W+1:2] == IDX_ADDR);
    strobe.wrPlain  = wrHit && busAddr[IDX_W+1];
  end
endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] wdata,
  input  logic              periphIrq,
  output logic [WORD_W-1:0] rdata,
  output logic              irqOut,
  output logic              devResetPulse,
  output logic              dmaEnable
);
  localparam int PLAIN_CNT = REG_CNT - 2;

  logic [WORD_W-1:0] ctrlReg;
  logic [WORD_W-1:0] addrReg;
  logic [WORD_W-1:0] plainReg [PLAIN_CNT];
  logic [WORD_W-1:0] ctrlShaped;
  logic [WORD_W-1:0] ctrlNext;
  logic              pulseReg;

  // Side-effect rewrite of a control write, reset bit takes precedence.
  always_comb begin
    ctrlShaped = wdata;
    if (!wdata[B_DRST]) begin
      if (wdata[B_DRAIN])
        ctrlShaped[B_DRAIN] = 1'b0;
      else if (wdata == '0)
        ctrlShaped = WORD_W'(1) << B_DRAIN;
    end
  end

  always_comb begin
    ctrlNext = ctrlReg;
    if (strobe.wrCtrl)
      ctrlNext = (ctrlReg & RO_MASK) | (ctrlShaped & ~RO_MASK) | VERSION_VAL;
    if (strobe.wrAddr)
      ctrlNext[B_LOADED] = 1'b1;
    ctrlNext[B_PEND] = periphIrq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg  <= VERSION_VAL;
      addrReg  <= '0;
      pulseReg <= 1'b0;
    end else begin
      ctrlReg  <= ctrlNext;
      pulseReg <= strobe.wrCtrl && wdata[B_DRST];
      if (strobe.wrAddr)
        addrReg <= wdata;
    end
  end

  for (genvar g = 0; g < PLAIN_CNT; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)
        plainReg[g] <= '0;
      else if (strobe.wrPlain && (strobe.idx[0] == 1'(g)))
        plainReg[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.inWindow) begin
      case (strobe.idx)
        2'd0:    rdata = ctrlReg;
        2'd1:    rdata = addrReg;
        2'd2:    rdata = plainReg[0];
        default: rdata = plainReg[1];
      endcase
    end
  end

  assign irqOut        = ctrlReg[B_PEND] && ctrlReg[B_IEN];
  assign dmaEnable     = ctrlReg[B_EN];
  assign devResetPulse = pulseReg;
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDE_WINDOW = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              periphIrq,
  output logic              irqOut,
  output logic              devResetPulse,
  output logic              dmaEnable
);
  regStrobe_t strobe;

  dma_ctl_decode #(
    .ADDR_W     (ADDR_W),
    .WIDE_WINDOW(WIDE_WINDOW)
  ) u_decode (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  dma_ctl_regfile u_regfile (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .wdata        (busWdata),
    .periphIrq    (periphIrq),
    .rdata        (busRdata),
    .irqOut       (irqOut),
    .devResetPulse(devResetPulse),
    .dmaEnable    (dmaEnable)
  );
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int ADDR_W      = 8,
  parameter int WIDE_WINDOW = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              periphIrq,
  input logic              irqOut,
  input logic              devResetPulse,
  input logic              dmaEnable
);
  logic inWin, ctrlWr, addrWr, ctrlRd;
  assign inWin  = (WIDE_WINDOW == 0) || (busAddr <= ADDR_W'(31));
  assign ctrlWr = busValid && busWrite && inWin && (busAddr[3:2] == 2'd0);
  assign addrWr = busValid && busWrite && inWin && (busAddr[3:2] == 2'd1);
  assign ctrlRd = busValid && !busWrite && inWin && (busAddr[3:2] == 2'd0);

  p_version_r3: assert property (@(posedge clk) disable iff (rst)
    ctrlRd |-> (busRdata[31] && busRdata[29] && busRdata[2:1] == 2'b00));

  p_pulse_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && busWdata[7]) |=> devResetPulse);

  p_pulse_only_r4: assert property (@(posedge clk) disable iff (rst)
    !(ctrlWr && busWdata[7]) |=> !devResetPulse);

  p_enable_set_r7: assert property (@(posedge clk) disable iff (rst)
    ctrlWr |=> (dmaEnable == $past(busWdata[9])));

  p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrlWr |=> $stable(dmaEnable));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(periphIrq));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrlRd && !busRdata[4]) |-> !irqOut);

  p_loaded_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrlRd && $past(addrWr)) |-> busRdata[26]);

  p_window_r12: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && !inWin) |-> (busRdata == 32'h0));
endmodule

bind dma_ctl_regs dma_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .WIDE_WINDOW(WIDE_WINDOW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busValid     (busValid),
  .busWrite     (busWrite),
  .busAddr      (busAddr),
  .busWdata     (busWdata),
  .busRdata     (busRdata),
  .periphIrq    (periphIrq),
  .irqOut       (irqOut),
  .devResetPulse(devResetPulse),
  .dmaEnable    (dmaEnable)
);

// File: tb/test_dma_ctl_regs.sv
`timescale 1ns/1ps
module test_dma_ctl_regs;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          periphIrq = 1'b0;
  logic          irqOut, devResetPulse, dmaEnable;

  int nRun = 0;
  int nFail = 0;

  // reference model state
  logic [31:0] mWord [4];
  logic        mPulse;

  always #5 clk = ~clk;

  dma_ctl_regs #(.ADDR_W(AW), .WIDE_WINDOW(1)) i_dma_ctl_regs (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periphIrq(periphIrq), .irqOut(irqOut),
    .devResetPulse(devResetPulse), .dmaEnable(dmaEnable)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    if (a > 8'h1F) return 32'h0;
    return mWord[a[3:2]];
  endfunction

  task automatic modelReset();
    mWord[0] = 32'hA000_0000;
    mWord[1] = 0; mWord[2] = 0; mWord[3] = 0;
    mPulse   = 1'b0;
  endtask

  task automatic modelClock(input logic v, input logic w, input logic [AW-1:0] a,
                            input logic [31:0] d, input logic irq);
    logic [31:0] val;
    logic        hit;
    hit    = v && w && (a <= 8'h1F);
    mPulse = 1'b0;
    if (hit) begin
      case (a[3:2])
        2'd0: begin
          val = d;
          if (d[7]) mPulse = 1'b1;
          else if (d[6]) val[6] = 1'b0;
          else if (d == 0) val = 32'h40;
          mWord[0] = (mWord[0] & 32'hFE00_0007) | (val & 32'h01FF_FFF8) | 32'hA000_0000;
        end
        2'd1: begin mWord[1] = d; mWord[0][26] = 1'b1; end
        default: mWord[a[3:2]] = d;
      endcase
    end
    mWord[0][0] = irq;
  endtask

  task automatic step(input string tag, input logic v, input logic w,
                      input logic [AW-1:0] a, input logic [31:0] d, input logic irq);
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d; periphIrq = irq;
    #1;
    check(tag, "rdata", busRdata, modelRead(a));
    check(tag, "irqOut", {31'b0, irqOut}, {31'b0, mWord[0][0] & mWord[0][4]});
    check(tag, "dmaEnable", {31'b0, dmaEnable}, {31'b0, mWord[0][9]});
    check(tag, "devResetPulse", {31'b0, devResetPulse}, {31'b0, mPulse});
    @(posedge clk);
    modelClock(v, w, a, d, irq);
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, a, d, periphIrq);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    step(tag, 1'b1, 1'b0, a, 32'h0, periphIrq);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired before the scenarios ended");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd("R1", 8'h00); rd("R1", 8'h04); rd("R1", 8'h08); rd("R1", 8'h0C);
    @(negedge clk);
    check("R1", "irq after reset", {31'b0, irqOut}, 32'h0);

    // R11: plain storage, R2: aliasing across upper half
    wr("R11", 8'h08, 32'h1234_5678);
    wr("R11", 8'h0C, 32'hCAFE_F00D);
    rd("R11", 8'h08); rd("R11", 8'h0C); rd("R11", 8'h00); rd("R11", 8'h04);
    rd("R2", 8'h18); rd("R2", 8'h1C);
    wr("R2", 8'h1C, 32'h0BAD_BEEF);
    rd("R2", 8'h0C); rd("R2", 8'h08);

    // R10: address write sets loaded flag
    wr("R10", 8'h04, 32'h0000_1000);
    rd("R10", 8'h00); rd("R10", 8'h04);

    // R6: zero write becomes drain
    wr("R6", 8'h00, 32'h0);
    rd("R6", 8'h00);
    // R5: drain bit alone is stripped
    wr("R5", 8'h00, 32'h0000_0140);
    rd("R5", 8'h00);
    // R3, R4: all ones, read-only bits retained, reset pulse
    wr("R3", 8'h00, 32'hFFFF_FFFF);
    rd("R4", 8'h00);
    rd("R4", 8'h00);
    wr("R4", 8'h00, 32'h0000_0080);
    wr("R4", 8'h00, 32'h0000_0080);
    rd("R4", 8'h00);
    // R10: loaded stays after control writes
    rd("R10", 8'h00);

    // R7: enable follows bit 9
    wr("R7", 8'h00, 32'h0000_0200);
    rd("R7", 8'h00);
    wr("R7", 8'h10, 32'h0000_0200);
    wr("R7", 8'h00, 32'h0);
    rd("R7", 8'h00);

    // R8, R9: pending and gating
    step("R8", 1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
    rd("R8", 8'h00);
    wr("R9", 8'h00, 32'h0000_0010);
    rd("R9", 8'h00); rd("R9", 8'h00);
    step("R8", 1'b1, 1'b0, 8'h00, 32'h0, 1'b0);
    rd("R8", 8'h00);
    step("R9", 1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
    wr("R9", 8'h00, 32'h0000_0200);
    rd("R9", 8'h00);
    wr("R9", 8'h00, 32'h0000_0210);
    rd("R9", 8'h00);

    // R12: out-of-window accesses
    wr("R12", 8'h20, 32'hFFFF_FFFF);
    wr("R12", 8'h24, 32'h5555_AAAA);
    wr("R12", 8'hE8, 32'h7777_7777);
    rd("R12", 8'h20); rd("R12", 8'hFC);
    rd("R12", 8'h00); rd("R12", 8'h04); rd("R12", 8'h08);

    step("R1", 1'b0, 1'b0, 8'h00, 32'h0, 1'b0);
    step("R1", 1'b0, 1'b0, 8'h00, 32'h0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule